// File: doc/BRIEF.md
# Flash Command Interface Controller

This block models the command front end of a byte-wide flash memory that is erased one block at a time. A host drives chip enable, output enable, write enable, an active-low reset/power-down line, an address and a data byte. All of them are sampled on a system clock. Each completed bus write is decoded as a command. The controller keeps track of what a read returns: array data, identifier codes or the status byte. It arms the two-write sequences that alter memory. Before it starts a timed erase, byte write or lock change, it checks the supply-good input, the per-block lock bits and the master lock bit.

The storage is a small register file. Each block holds a few bytes, and the low address bits pick the byte. A second input, the override level of reset, stands for the high-voltage unlock level and bypasses the lock checks. While an operation runs, the ready output is low, every read returns the status byte and further commands are ignored.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset, and after the power-down line returns high, reads return array data and the status byte reads 80h with ready high. Power-up contents are FFh in every byte, and all lock bits are clear.
- R2: A bus write is taken when the chip enable or write enable input rises after both were low, whichever rises first. The address and data are those present while both were low. Writes are ignored while the power-down line is low.
- R3: The data outputs are enabled only while chip enable and output enable are both low and the power-down line is high.
- R4: Command FFh selects array reads, 90h selects identifier reads and 70h selects status reads. Command 50h clears status bits 5, 4, 3 and 1.
- R5: In identifier mode, in-block offset 2 of any block returns that block's lock bit in bit 0. In block 0, offset 0 returns the manufacturer code, offset 1 returns the device code and offset 3 returns the master lock bit in bit 0.
- R6: A byte write is 40h or 10h followed by an address/data write. The addressed byte becomes its old value AND the data. The block is the top three address bits and the byte is the low address bits.
- R7: Block erase is 20h followed by D0h at any address inside the block. It sets every byte of that block to FFh.
- R8: After 20h or 60h, a second write that is not a valid confirm sets status bits 5 and 4. It starts nothing and leaves status reads selected.
- R9: An accepted operation holds ready low for exactly OP_CYCLES clocks. While ready is low, reads return the status byte with bit 7 at 0, and commands are ignored.
- R10: An erase or write to a block whose lock bit is set is rejected while the override input is low. The rejection sets status bit 1, plus bit 5 for an erase or bit 4 for a write. With the override high, the operation proceeds.
- R11: Lock setup is 60h. It is followed by 01h to set the lock bit of the addressed block, F1h to set the master bit, or D0h to clear all block lock bits. Setting the master bit needs the override. Block lock changes need the override while the master bit is set. A rejection sets bit 1, plus bit 4 for a set or bit 5 for a clear.
- R12: When supply-good is low, any erase, write or lock change is rejected. The rejection sets status bit 3, plus bit 5 or bit 4, and the memory is left unchanged.
- R13: Driving the power-down line low during an operation aborts it without changing memory. Ready goes high, and afterwards status reads 80h and array reads are selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low power-up reset |
| ce_ni | input | 1 | Chip enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| we_ni | input | 1 | Write enable, active low |
| rp_ni | input | 1 | Reset/power-down, active low |
| rp_hv_i | input | 1 | Reset at override level, bypasses lock checks |
| vpp_ok_i | input | 1 | Programming supply good |
| addr_i | input | ADDR_W | Byte address |
| data_i | input | 8 | Write data and commands |
| data_o | output | 8 | Read data |
| data_oe_o | output | 1 | Output drive enable; low means high impedance |
| ready_o | output | 1 | High when no operation runs |

## Verification
A wrong read mode or a lost armed state shows on the very next read, because the byte returned has the wrong source. The clearest case is a stale status byte where array data is expected. A wrong lock decision shows at once: ready either fails to drop in the cycle after the confirm write, or it drops when it should not. The status byte carries the matching error bits. A wrong operation counter or a missed abort shows as a low-ready window that differs from OP_CYCLES. A misapplied erase or write stays hidden until the block is read back in array mode.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  localparam logic [7:0] CMD_READ_ARRAY  = 8'hFF;
  localparam logic [7:0] CMD_READ_ID     = 8'h90;
  localparam logic [7:0] CMD_READ_SR     = 8'h70;
  localparam logic [7:0] CMD_CLR_SR      = 8'h50;
  localparam logic [7:0] CMD_ERASE_SETUP = 8'h20;
  localparam logic [7:0] CMD_CONFIRM     = 8'hD0;
  localparam logic [7:0] CMD_WRITE_SETUP = 8'h40;
  localparam logic [7:0] CMD_WRITE_ALT   = 8'h10;
  localparam logic [7:0] CMD_LOCK_SETUP  = 8'h60;
  localparam logic [7:0] CMD_SET_BLK     = 8'h01;
  localparam logic [7:0] CMD_SET_MST     = 8'hF1;

  localparam int SR_ERASE_ERR = 5;
  localparam int SR_PROG_ERR  = 4;
  localparam int SR_VPP_LOW   = 3;
  localparam int SR_LOCKED    = 1;

  typedef enum logic [1:0] {RD_ARRAY, RD_ID, RD_STATUS} rd_mode_e;
  typedef enum logic [1:0] {ARM_NONE, ARM_ERASE, ARM_WRITE, ARM_LOCK} arm_e;
  typedef enum logic [2:0] {OP_NONE, OP_ERASE, OP_WRITE, OP_SET_BLK,
                            OP_SET_MST, OP_CLR_LOCKS} op_e;
endpackage

// File: rtl/flash_bus_capture.sv
module flash_bus_capture #(
  parameter int KEY_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ce_ni,
  input  logic             we_ni,
  input  logic             rp_ni,
  input  logic [KEY_W-1:0] key_i,
  input  logic [7:0]       data_i,
  output logic             commit_o,
  output logic [KEY_W-1:0] key_o,
  output logic [7:0]       data_o
);
  logic act, act_q;
  logic [KEY_W-1:0] key_q;
  logic [7:0] data_q;

  assign act = !ce_ni && !we_ni && rp_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      key_q  <= '0;
      data_q <= '0;
    end else begin
      act_q <= act;
      if (act) begin
        key_q  <= key_i;
        data_q <= data_i;
      end
    end
  end

  // first rising enable ends the write
  assign commit_o = act_q && !act && rp_ni;
  assign key_o    = key_q;
  assign data_o   = data_q;
endmodule

// File: rtl/flash_op_timer.sv
module flash_op_timer #(
  parameter int OP_CYCLES = 16,
  parameter int CNT_W     = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic abort_i,
  output logic busy_o,
  output logic done_o
);
  logic busy_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (abort_i) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i && !busy_q) begin
      busy_q <= 1'b1;
      cnt_q  <= CNT_W'(OP_CYCLES - 1);
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign done_o = busy_q && (cnt_q == '0) && !abort_i;
endmodule

// File: rtl/flash_store.sv
module flash_store
  import flash_cmd_pkg::*;
#(
  parameter int NUM_BLK = 8,
  parameter int WORDS   = 4,
  parameter int BLK_W   = 3,
  parameter int WORD_W  = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               apply_i,
  input  op_e                op_i,
  input  logic [BLK_W-1:0]   blk_i,
  input  logic [WORD_W-1:0]  word_i,
  input  logic [7:0]         data_i,
  input  logic [BLK_W-1:0]   rd_blk_i,
  input  logic [WORD_W-1:0]  rd_word_i,
  output logic [7:0]         rd_data_o,
  output logic [NUM_BLK-1:0] blk_lock_o,
  output logic               mst_lock_o
);
  logic [7:0] rd_bank [NUM_BLK];
  logic mst_q;

  for (genvar b = 0; b < NUM_BLK; b++) begin : g_blk
    logic [7:0] cell_q [WORDS];
    logic lock_q;
    logic hit;
    assign hit = (blk_i == BLK_W'(b));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int w = 0; w < WORDS; w++) cell_q[w] <= 8'hFF;
        lock_q <= 1'b0;
      end else if (apply_i) begin
        if (hit && op_i == OP_ERASE)
          for (int w = 0; w < WORDS; w++) cell_q[w] <= 8'hFF;
        if (hit && op_i == OP_WRITE)
          cell_q[word_i] <= cell_q[word_i] & data_i;
        if (hit && op_i == OP_SET_BLK) lock_q <= 1'b1;
        if (op_i == OP_CLR_LOCKS)      lock_q <= 1'b0;
      end
    end

    assign rd_bank[b]    = cell_q[rd_word_i];
    assign blk_lock_o[b] = lock_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              mst_q <= 1'b0;
    else if (apply_i && op_i == OP_SET_MST)   mst_q <= 1'b1;
  end

  assign mst_lock_o = mst_q;
  assign rd_data_o  = rd_bank[rd_blk_i];
endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
  import flash_cmd_pkg::*;
#(
  parameter int NUM_BLK = 8,
  parameter int BLK_W   = 3,
  parameter int WORD_W  = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               rp_ni,
  input  logic               rp_hv_i,
  input  logic               vpp_ok_i,
  input  logic               commit_i,
  input  logic [BLK_W-1:0]   cblk_i,
  input  logic [WORD_W-1:0]  cword_i,
  input  logic [7:0]         cdata_i,
  input  logic               busy_i,
  input  logic [NUM_BLK-1:0] blk_lock_i,
  input  logic               mst_lock_i,
  output rd_mode_e           mode_o,
  output logic [6:0]         sr_o,
  output logic               start_o,
  output op_e                op_o,
  output logic [BLK_W-1:0]   op_blk_o,
  output logic [WORD_W-1:0]  op_word_o,
  output logic [7:0]         op_data_o
);
  rd_mode_e mode_q, mode_d;
  arm_e arm_q, arm_d;
  logic [6:0] sr_q, sr_d;
  op_e op_q, op_d, try_op;
  logic [BLK_W-1:0] blk_q, blk_d;
  logic [WORD_W-1:0] word_q, word_d;
  logic [7:0] data_q, data_d;
  logic start, seq_err, denied;
  int err_bit;

  always_comb begin
    mode_d  = mode_q;
    arm_d   = arm_q;
    sr_d    = sr_q;
    op_d    = op_q;
    blk_d   = blk_q;
    word_d  = word_q;
    data_d  = data_q;
    try_op  = OP_NONE;
    seq_err = 1'b0;
    start   = 1'b0;
    denied  = 1'b0;
    err_bit = SR_PROG_ERR;

    if (commit_i && !busy_i) begin
      unique case (arm_q)
        ARM_NONE: begin
          unique case (cdata_i)
            CMD_READ_ARRAY:  mode_d = RD_ARRAY;
            CMD_READ_ID:     mode_d = RD_ID;
            CMD_READ_SR:     mode_d = RD_STATUS;
            CMD_CLR_SR: begin
              sr_d[SR_ERASE_ERR] = 1'b0;
              sr_d[SR_PROG_ERR]  = 1'b0;
              sr_d[SR_VPP_LOW]   = 1'b0;
              sr_d[SR_LOCKED]    = 1'b0;
            end
            CMD_ERASE_SETUP: begin arm_d = ARM_ERASE; mode_d = RD_STATUS; end
            CMD_WRITE_SETUP,
            CMD_WRITE_ALT:   begin arm_d = ARM_WRITE; mode_d = RD_STATUS; end
            CMD_LOCK_SETUP:  begin arm_d = ARM_LOCK;  mode_d = RD_STATUS; end
            default: ;
          endcase
        end
        ARM_ERASE: begin
          if (cdata_i == CMD_CONFIRM) try_op = OP_ERASE;
          else                        seq_err = 1'b1;
        end
        ARM_WRITE: try_op = OP_WRITE;
        ARM_LOCK: begin
          unique case (cdata_i)
            CMD_SET_BLK: try_op = OP_SET_BLK;
            CMD_SET_MST: try_op = OP_SET_MST;
            CMD_CONFIRM: try_op = OP_CLR_LOCKS;
            default:     seq_err = 1'b1;
          endcase
        end
        default: ;
      endcase

      if (arm_q != ARM_NONE) begin
        arm_d  = ARM_NONE;
        mode_d = RD_STATUS;
      end
    end

    if (seq_err) begin
      sr_d[SR_ERASE_ERR] = 1'b1;
      sr_d[SR_PROG_ERR]  = 1'b1;
    end

    if (try_op != OP_NONE) begin
      if (try_op == OP_ERASE || try_op == OP_CLR_LOCKS) err_bit = SR_ERASE_ERR;
      unique case (try_op)
        OP_ERASE, OP_WRITE:        denied = blk_lock_i[cblk_i] && !rp_hv_i;
        OP_SET_BLK, OP_CLR_LOCKS:  denied = mst_lock_i && !rp_hv_i;
        OP_SET_MST:                denied = !rp_hv_i;
        default:                   denied = 1'b0;
      endcase
      if (!vpp_ok_i) begin
        sr_d[err_bit]    = 1'b1;
        sr_d[SR_VPP_LOW] = 1'b1;
      end else if (denied) begin
        sr_d[err_bit]   = 1'b1;
        sr_d[SR_LOCKED] = 1'b1;
      end else begin
        start  = 1'b1;
        op_d   = try_op;
        blk_d  = cblk_i;
        word_d = cword_i;
        data_d = cdata_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= RD_ARRAY;
      arm_q  <= ARM_NONE;
      sr_q   <= '0;
      op_q   <= OP_NONE;
      blk_q  <= '0;
      word_q <= '0;
      data_q <= '0;
    end else if (!rp_ni) begin
      mode_q <= RD_ARRAY;
      arm_q  <= ARM_NONE;
      sr_q   <= '0;
      op_q   <= OP_NONE;
    end else begin
      mode_q <= mode_d;
      arm_q  <= arm_d;
      sr_q   <= sr_d;
      op_q   <= op_d;
      blk_q  <= blk_d;
      word_q <= word_d;
      data_q <= data_d;
    end
  end

  assign mode_o    = mode_q;
  assign sr_o      = sr_q;
  assign start_o   = start && rp_ni;
  assign op_o      = op_q;
  assign op_blk_o  = blk_q;
  assign op_word_o = word_q;
  assign op_data_o = data_q;
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int         ADDR_W        = 19,
  parameter int         NUM_BLK       = 8,
  parameter int         WORDS_PER_BLK = 4,
  parameter int         OP_CYCLES     = 16,
  parameter logic [7:0] MFR_CODE      = 8'h5A,
  parameter logic [7:0] DEV_CODE      = 8'hC3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic              we_ni,
  input  logic              rp_ni,
  input  logic              rp_hv_i,
  input  logic              vpp_ok_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  output logic [7:0]        data_o,
  output logic              data_oe_o,
  output logic              ready_o
);
  localparam int BLK_W  = $clog2(NUM_BLK);
  localparam int WORD_W = $clog2(WORDS_PER_BLK);
  localparam int OFF_W  = ADDR_W - BLK_W;
  localparam int KEY_W  = BLK_W + WORD_W;
  localparam int CNT_W  = $clog2(OP_CYCLES + 1);

  logic [BLK_W-1:0]  rd_blk;
  logic [WORD_W-1:0] rd_word;
  logic [OFF_W-1:0]  rd_off;
  logic [KEY_W-1:0]  key_in, key_cap;
  logic [7:0]        cdata;
  logic              commit, busy, done, start;
  rd_mode_e          mode;
  logic [6:0]        sr;
  op_e               op;
  logic [BLK_W-1:0]  op_blk;
  logic [WORD_W-1:0] op_word;
  logic [7:0]        op_data, arr_data, id_data, rd_mux;
  logic [NUM_BLK-1:0] blk_lock;
  logic              mst_lock;

  assign rd_blk  = addr_i[ADDR_W-1 -: BLK_W];
  assign rd_word = addr_i[WORD_W-1:0];
  assign rd_off  = addr_i[OFF_W-1:0];
  assign key_in  = {rd_blk, rd_word};

  flash_bus_capture #(.KEY_W(KEY_W)) u_cap (
    .clk_i, .rst_ni, .ce_ni, .we_ni, .rp_ni,
    .key_i(key_in), .data_i,
    .commit_o(commit), .key_o(key_cap), .data_o(cdata)
  );

  flash_cmd_fsm #(.NUM_BLK(NUM_BLK), .BLK_W(BLK_W), .WORD_W(WORD_W)) u_fsm (
    .clk_i, .rst_ni, .rp_ni, .rp_hv_i, .vpp_ok_i,
    .commit_i(commit),
    .cblk_i(key_cap[KEY_W-1 -: BLK_W]),
    .cword_i(key_cap[WORD_W-1:0]),
    .cdata_i(cdata),
    .busy_i(busy),
    .blk_lock_i(blk_lock), .mst_lock_i(mst_lock),
    .mode_o(mode), .sr_o(sr), .start_o(start),
    .op_o(op), .op_blk_o(op_blk), .op_word_o(op_word), .op_data_o(op_data)
  );

  flash_op_timer #(.OP_CYCLES(OP_CYCLES), .CNT_W(CNT_W)) u_tmr (
    .clk_i, .rst_ni,
    .start_i(start), .abort_i(!rp_ni),
    .busy_o(busy), .done_o(done)
  );

  flash_store #(.NUM_BLK(NUM_BLK), .WORDS(WORDS_PER_BLK),
                .BLK_W(BLK_W), .WORD_W(WORD_W)) u_store (
    .clk_i, .rst_ni,
    .apply_i(done), .op_i(op), .blk_i(op_blk), .word_i(op_word), .data_i(op_data),
    .rd_blk_i(rd_blk), .rd_word_i(rd_word), .rd_data_o(arr_data),
    .blk_lock_o(blk_lock), .mst_lock_o(mst_lock)
  );

  always_comb begin
    id_data = 8'h00;
    if (rd_off == OFF_W'(2))
      id_data = {7'd0, blk_lock[rd_blk]};
    else if (rd_blk == '0) begin
      if (rd_off == OFF_W'(0))      id_data = MFR_CODE;
      else if (rd_off == OFF_W'(1)) id_data = DEV_CODE;
      else if (rd_off == OFF_W'(3)) id_data = {7'd0, mst_lock};
    end
  end

  always_comb begin
    if (busy || mode == RD_STATUS) rd_mux = {!busy, sr};
    else if (mode == RD_ID)        rd_mux = id_data;
    else                           rd_mux = arr_data;
  end

  assign data_oe_o = !ce_ni && !oe_ni && rp_ni;
  assign data_o    = data_oe_o ? rd_mux : 8'h00;
  assign ready_o   = !busy;
endmodule

// File: rtl/flash_cmd_ctrl_chk.sv
module flash_cmd_ctrl_chk #(
  parameter int OP_CYCLES = 16
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ce_ni,
  input logic       oe_ni,
  input logic       we_ni,
  input logic       rp_ni,
  input logic [7:0] data_o,
  input logic       data_oe_o,
  input logic       ready_o
);
  int unsigned low_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      low_cnt <= 0;
    else if (!ready_o) low_cnt <= low_cnt + 1;
    else               low_cnt <= 0;
  end

  // R3
  oe_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_ni || oe_ni || !rp_ni) |-> !data_oe_o);

  // R9
  busy_status_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready_o && data_oe_o) |-> !data_o[7]);

  // R9
  busy_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(ready_o) && $past(rp_ni)) |-> (low_cnt == OP_CYCLES));

  // R9
  busy_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |-> (low_cnt < OP_CYCLES));

  // R13
  pd_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rp_ni |=> ready_o);

  // R2
  start_after_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ready_o) |-> (!$past(we_ni, 2) && !$past(ce_ni, 2) &&
                        ($past(we_ni) || $past(ce_ni))));
endmodule

bind flash_cmd_ctrl flash_cmd_ctrl_chk #(.OP_CYCLES(OP_CYCLES)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ce_ni(ce_ni), .oe_ni(oe_ni),
  .we_ni(we_ni), .rp_ni(rp_ni), .data_o(data_o),
  .data_oe_o(data_oe_o), .ready_o(ready_o)
);

// File: tb/tb_flash_cmd_ctrl.sv
`timescale 1ns/1ps
module tb_flash_cmd_ctrl;
  localparam int OPC = 16;
  localparam logic [7:0] MFR = 8'h5A;
  localparam logic [7:0] DEV = 8'hC3;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic ce_ni = 1'b1, oe_ni = 1'b1, we_ni = 1'b1, rp_ni = 1'b1;
  logic rp_hv_i = 1'b0, vpp_ok_i = 1'b1;
  logic [18:0] addr_i = '0;
  logic [7:0] data_i = '0;
  logic [7:0] data_o;
  logic data_oe_o, ready_o;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  flash_cmd_ctrl #(.OP_CYCLES(OPC), .MFR_CODE(MFR), .DEV_CODE(DEV)) dut (
    .clk_i(clk), .rst_ni, .ce_ni, .oe_ni, .we_ni, .rp_ni, .rp_hv_i,
    .vpp_ok_i, .addr_i, .data_i, .data_o, .data_oe_o, .ready_o
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [18:0] a, input logic [7:0] d);
    @(negedge clk);
    addr_i = a; data_i = d; ce_ni = 1'b0; we_ni = 1'b0;
    @(negedge clk);
    we_ni = 1'b1; ce_ni = 1'b1;
    @(negedge clk);
  endtask

  // chip enable rises first
  task automatic bus_wr_ce(input logic [18:0] a, input logic [7:0] d);
    @(negedge clk);
    addr_i = a; data_i = d; ce_ni = 1'b0; we_ni = 1'b0;
    @(negedge clk);
    ce_ni = 1'b1;
    @(negedge clk);
    we_ni = 1'b1;
  endtask

  task automatic bus_rd(input logic [18:0] a, output logic [7:0] v);
    @(negedge clk);
    addr_i = a; ce_ni = 1'b0; oe_ni = 1'b0;
    #1 v = data_o;
    #1 ce_ni = 1'b1; oe_ni = 1'b1;
  endtask

  task automatic wait_ready(output int n);
    n = 0;
    while (!ready_o && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    logic [7:0] v;
    @(negedge clk);
    chk("R3 deselected drive", {7'd0, data_oe_o}, 8'h00);
    chk("R1 ready after reset", {7'd0, ready_o}, 8'h01);
    bus_rd(19'h00005, v); chk("R1 array after reset", v, 8'hFF);
    bus_wr(0, 8'h70);
    bus_rd(0, v); chk("R1 R4 status after reset", v, 8'h80);
  endtask

  task automatic t_ident;
    logic [7:0] v;
    bus_wr(0, 8'h90);
    bus_rd(19'h00000, v); chk("R5 manufacturer", v, MFR);
    bus_rd(19'h00001, v); chk("R5 device", v, DEV);
    bus_rd(19'h30002, v); chk("R5 block lock clear", v, 8'h00);
    bus_rd(19'h00003, v); chk("R5 master clear", v, 8'h00);
  endtask

  task automatic t_write;
    logic [7:0] v;
    int n;
    bus_wr(19'h20000, 8'h40);
    bus_wr(19'h20001, 8'h3C);
    bus_rd(19'h20001, v); chk("R9 read while busy", v, 8'h00);
    bus_wr(0, 8'h90); // ignored while busy
    wait_ready(n);
    bus_rd(19'h20001, v); chk("R9 command ignored while busy", v, 8'h80);
    bus_wr(0, 8'hFF);
    bus_rd(19'h20001, v); chk("R6 byte written", v, 8'h3C);
    bus_wr(19'h20000, 8'h10);
    bus_wr_ce(19'h20001, 8'hF5);
    wait_ready(n);
    bus_wr(0, 8'hFF);
    bus_rd(19'h20001, v); chk("R2 R6 and-merge", v, 8'h34);
    bus_rd(19'h20002, v); chk("R6 neighbour untouched", v, 8'hFF);
  endtask

  task automatic t_erase;
    logic [7:0] v;
    int n;
    bus_wr(19'h20000, 8'h20);
    bus_wr(19'h2ABCD, 8'hD0);
    wait_ready(n);
    chk("R9 busy length", 8'(n), 8'(OPC));
    bus_wr(0, 8'hFF);
    bus_rd(19'h20001, v); chk("R7 erased", v, 8'hFF);
  endtask

  task automatic t_seq_err;
    logic [7:0] v;
    bus_wr(0, 8'h20);
    bus_wr(0, 8'hFF);
    chk("R8 no start", {7'd0, ready_o}, 8'h01);
    bus_rd(0, v); chk("R8 sequence error", v, 8'hB0);
    bus_wr(0, 8'h50);
    bus_rd(0, v); chk("R4 clear status", v, 8'h80);
  endtask

  task automatic t_block_lock;
    logic [7:0] v;
    int n;
    bus_wr(19'h30000, 8'h60);
    bus_wr(19'h30000, 8'h01);
    wait_ready(n);
    bus_wr(0, 8'h90);
    bus_rd(19'h30002, v); chk("R11 block lock set", v, 8'h01);
    bus_wr(19'h30000, 8'h40);
    bus_wr(19'h30000, 8'h00);
    chk("R10 locked write no start", {7'd0, ready_o}, 8'h01);
    bus_rd(0, v); chk("R10 locked write status", v, 8'h92);
    bus_wr(0, 8'h50);
    bus_wr(19'h30000, 8'h20);
    bus_wr(19'h30000, 8'hD0);
    bus_rd(0, v); chk("R10 locked erase status", v, 8'hA2);
    bus_wr(0, 8'h50);
    rp_hv_i = 1'b1;
    bus_wr(19'h30000, 8'h40);
    bus_wr(19'h30001, 8'h0F);
    wait_ready(n);
    rp_hv_i = 1'b0;
    bus_wr(0, 8'hFF);
    bus_rd(19'h30001, v); chk("R10 override write", v, 8'h0F);
  endtask

  task automatic t_master;
    logic [7:0] v;
    int n;
    bus_wr(0, 8'h60);
    bus_wr(0, 8'hF1);
    bus_rd(0, v); chk("R11 master needs override", v, 8'h92);
    bus_wr(0, 8'h50);
    rp_hv_i = 1'b1;
    bus_wr(0, 8'h60);
    bus_wr(0, 8'hF1);
    wait_ready(n);
    rp_hv_i = 1'b0;
    bus_wr(0, 8'h90);
    bus_rd(19'h00003, v); chk("R11 master set", v, 8'h01);
    bus_wr(0, 8'h60);
    bus_wr(0, 8'hD0);
    bus_rd(0, v); chk("R11 clear blocked by master", v, 8'hA2);
    bus_wr(0, 8'h50);
    rp_hv_i = 1'b1;
    bus_wr(0, 8'h60);
    bus_wr(0, 8'hD0);
    wait_ready(n);
    rp_hv_i = 1'b0;
    bus_wr(0, 8'h90);
    bus_rd(19'h30002, v); chk("R11 locks cleared", v, 8'h00);
  endtask

  task automatic t_vpp;
    logic [7:0] v;
    vpp_ok_i = 1'b0;
    bus_wr(19'h10000, 8'h40);
    bus_wr(19'h10000, 8'h00);
    chk("R12 no start", {7'd0, ready_o}, 8'h01);
    bus_rd(0, v); chk("R12 supply error", v, 8'h98);
    vpp_ok_i = 1'b1;
    bus_wr(0, 8'h50);
    bus_wr(0, 8'hFF);
    bus_rd(19'h10000, v); chk("R12 memory unchanged", v, 8'hFF);
  endtask

  task automatic t_abort;
    logic [7:0] v;
    bus_wr(19'h40000, 8'h40);
    bus_wr(19'h40000, 8'h00);
    chk("R9 busy started", {7'd0, ready_o}, 8'h00);
    repeat (3) @(negedge clk);
    rp_ni = 1'b0;
    @(negedge clk);
    chk("R13 ready after abort", {7'd0, ready_o}, 8'h01);
    ce_ni = 1'b0; oe_ni = 1'b0;
    #1 chk("R3 no drive in power-down", {7'd0, data_oe_o}, 8'h00);
    ce_ni = 1'b1; oe_ni = 1'b1;
    @(negedge clk);
    rp_ni = 1'b1;
    @(negedge clk);
    bus_rd(19'h40000, v); chk("R13 R1 array mode, unchanged", v, 8'hFF);
    bus_wr(0, 8'h70);
    bus_rd(0, v); chk("R13 status cleared", v, 8'h80);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    t_reset;
    t_ident;
    t_write;
    t_erase;
    t_seq_err;
    t_block_lock;
    t_master;
    t_vpp;
    t_abort;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule